// File: doc/BRIEF.md
# Fractional Audio Master Clock Divider

This block derives an audio master clock and a bit clock from a fast system clock. The master clock is the selected source rate scaled by a rational ratio M/N. A phase accumulator produces it: M is added on every selected source strobe, and one master tick is emitted each time the sum reaches N. An integer divider then turns master ticks into bit-clock strobes, and a frame (left/right) clock runs at one sixty-fourth of the bit rate.

Every clock in the block is expressed as a one-cycle enable in the system clock domain. `src0_stb` and `src1_stb` mark the edges of the two internal sources. `ext_stb` marks the edges of an external master clock, which is used directly when the fractional path is disabled. The divider settings are taken into shadow registers only while the bit clock is stopped, and only at a master-tick boundary. Software can therefore stop the bit clock, reprogram the dividers, and resume without any runt pulse reaching the outputs.

Top module: `audio_mclk_div`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `mclk_stb`, `bclk_rise` and `lrclk` are 0, and the accumulator and all counters are cleared.
- R2: With `frac_en`=1 and a valid ratio, each selected source strobe adds M to the accumulator. When the sum is N or more, N is subtracted and `mclk_stb` is 1 in the following cycle, so the average rate is the source rate times M/N.
- R3: `src_sel`=0 selects `src0_stb` and `src_sel`=1 selects `src1_stb`. Strobes on the unselected source have no effect.
- R4: A ratio is valid only if 1 ≤ M ≤ 512, 1 ≤ N ≤ 8192 and N ≥ 2·M. With an invalid shadow ratio and `frac_en`=1, no master tick is produced and the accumulator stays at 0.
- R5: With `frac_en`=0, the fractional path is bypassed and `mclk_stb` equals `ext_stb` delayed by one cycle.
- R6: The bit divider value D is the factor minus one. Each run of D+1 master ticks produces one `bclk_rise` pulse, in the cycle after the last tick of the run.
- R7: In bypass mode (`frac_en`=0), a divider value above 511 acts as 511, so the factor never exceeds 512.
- R8: `lrclk` toggles on every 32nd `bclk_rise` pulse and changes at no other time, giving one full frame period per 64 bit clocks.
- R9: While `bclk_stop` is 1, no `bclk_rise` is produced, starting from the cycle after the stop is seen. The bit and frame counters hold their values and resume from them when the stop is released.
- R10: `cfg_m`, `cfg_n` and `cfg_bdiv` are ignored while `bclk_stop` is 0. While it is 1, a differing setting is loaded on a tick boundary: a master tick, bypass mode, or an invalid current ratio. The load clears the accumulator and the bit counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src0_stb | input | 1 | Edge strobe of internal source 0 |
| src1_stb | input | 1 | Edge strobe of internal source 1 |
| ext_stb | input | 1 | Edge strobe of external master clock |
| src_sel | input | 1 | Internal source select (0: src0, 1: src1) |
| frac_en | input | 1 | 1: fractional divider, 0: external bypass |
| bclk_stop | input | 1 | Halts the bit clock; enables reprogramming |
| cfg_m | input | 10 | Ratio numerator M |
| cfg_n | input | 14 | Ratio denominator N |
| cfg_bdiv | input | 10 | Bit divider factor minus one |
| mclk_stb | output | 1 | Master clock tick strobe |
| bclk_rise | output | 1 | Bit clock strobe, one per bit period |
| lrclk | output | 1 | Frame clock, bit rate / 64 |

## Verification
The embedded assertions check every cycle that the accumulator stays below N, that no master tick is produced from an invalid ratio or without a source edge, that no bit strobe appears while stopped, that the shadow settings never move while running, and that the frame clock only changes with a bit strobe. Average rates, the bypass clamp, the ignoring of writes while running, and the resumption after a stop can only be seen over long windows. The bench shows these with its reference model and with tick counts gathered across its scenarios.

// File: rtl/audio_mclk_div.sv
module audio_mclk_div #(
  parameter int M_W     = 10,
  parameter int N_W     = 14,
  parameter int D_W     = 10,
  parameter int M_MAX   = 512,
  parameter int N_MAX   = 8192,
  parameter int BYP_MAX = 511,
  parameter int LR_HALF = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           src0_stb,
  input  logic           src1_stb,
  input  logic           ext_stb,
  input  logic           src_sel,
  input  logic           frac_en,
  input  logic           bclk_stop,
  input  logic [M_W-1:0] cfg_m,
  input  logic [N_W-1:0] cfg_n,
  input  logic [D_W-1:0] cfg_bdiv,
  output logic           mclk_stb,
  output logic           bclk_rise,
  output logic           lrclk
);
  localparam int LR_W = $clog2(LR_HALF);
  localparam int S_W  = N_W + 1;

  logic [M_W-1:0]  m_q;
  logic [N_W-1:0]  n_q;
  logic [D_W-1:0]  d_q;
  logic [N_W-1:0]  acc;
  logic [D_W-1:0]  bcnt;
  logic [LR_W-1:0] lcnt;

  wire [N_W-1:0] m_ext   = N_W'(m_q);
  wire [S_W-1:0] sum     = S_W'(acc) + S_W'(m_q);
  wire           cfg_ok  = (m_q != '0) && (n_q != '0) &&
                           (m_q <= M_W'(M_MAX)) && (n_q <= N_W'(N_MAX)) &&
                           ({1'b0, n_q} >= {m_ext, 1'b0});
  wire           sel_stb = src_sel ? src1_stb : src0_stb;
  wire           frac_tick = frac_en && cfg_ok && sel_stb && (sum >= S_W'(n_q));
  wire           boundary  = !frac_en || !cfg_ok || frac_tick;
  wire           cfg_new   = (cfg_m != m_q) || (cfg_n != n_q) || (cfg_bdiv != d_q);
  wire           load      = bclk_stop && boundary && cfg_new;
  wire [D_W-1:0] div_eff   = (!frac_en && (d_q > D_W'(BYP_MAX))) ? D_W'(BYP_MAX) : d_q;
  wire           bit_end   = bcnt >= div_eff;
  wire           lr_end    = lcnt == LR_W'(LR_HALF - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_q      <= '0;
      n_q      <= '0;
      d_q      <= '0;
      acc      <= '0;
      mclk_stb <= 1'b0;
    end else begin
      mclk_stb <= frac_en ? frac_tick : ext_stb;
      if (load) begin
        m_q <= cfg_m;
        n_q <= cfg_n;
        d_q <= cfg_bdiv;
        acc <= '0;
      end else if (!cfg_ok) begin
        acc <= '0;
      end else if (frac_en && sel_stb) begin
        acc <= frac_tick ? N_W'(sum - S_W'(n_q)) : N_W'(sum);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bcnt      <= '0;
      lcnt      <= '0;
      bclk_rise <= 1'b0;
      lrclk     <= 1'b0;
    end else if (load) begin
      bcnt      <= '0;
      bclk_rise <= 1'b0;
    end else if (mclk_stb && !bclk_stop) begin
      if (bit_end) begin
        bcnt      <= '0;
        bclk_rise <= 1'b1;
        lcnt      <= lr_end ? '0 : lcnt + 1'b1;
        if (lr_end) lrclk <= ~lrclk;
      end else begin
        bcnt      <= bcnt + 1'b1;
        bclk_rise <= 1'b0;
      end
    end else begin
      bclk_rise <= 1'b0;
    end
  end

  AST_ACC_BELOW_N: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ok |-> (acc < n_q)); // R2
  AST_MCLK_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    mclk_stb |-> $past(frac_en ? sel_stb : ext_stb)); // R5
  AST_NO_TICK_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (frac_en && !cfg_ok) |=> !mclk_stb); // R4
  AST_STOP_NO_BCLK: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_stop |=> !bclk_rise); // R9
  AST_CFG_HELD_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    !bclk_stop |=> ($stable(m_q) && $stable(n_q) && $stable(d_q))); // R10
  AST_LR_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (lrclk != $past(lrclk)) |-> bclk_rise); // R8
endmodule

// File: tb/audio_mclk_div_tb_top.sv
module audio_mclk_div_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic src0_stb = 0, src1_stb = 0, ext_stb = 0, src_sel = 0, frac_en = 1, bclk_stop = 1;
  logic [9:0]  cfg_m = 0;
  logic [13:0] cfg_n = 0;
  logic [9:0]  cfg_bdiv = 0;
  logic mclk_stb, bclk_rise, lrclk;

  int checks = 0, errors = 0;
  int n_mclk = 0, n_bclk = 0, n_lr = 0, n_ext = 0;
  logic lr_prev = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_mclk_div dut_i (
    .clk(clk), .rst_n(rst_n), .src0_stb(src0_stb), .src1_stb(src1_stb),
    .ext_stb(ext_stb), .src_sel(src_sel), .frac_en(frac_en), .bclk_stop(bclk_stop),
    .cfg_m(cfg_m), .cfg_n(cfg_n), .cfg_bdiv(cfg_bdiv),
    .mclk_stb(mclk_stb), .bclk_rise(bclk_rise), .lrclk(lrclk)
  );

  // behavioural reference
  int r_m, r_n, r_d, r_acc, r_bcnt, r_lcnt;
  bit r_mstb, r_brise, r_lr;
  always @(posedge clk) begin
    if (!rst_n) begin
      r_m = 0; r_n = 0; r_d = 0; r_acc = 0; r_bcnt = 0; r_lcnt = 0;
      r_mstb = 0; r_brise = 0; r_lr = 0;
    end else begin
      bit ok, sel, tick, bnd, ld, nm;
      int lim;
      ok   = r_m > 0 && r_n > 0 && r_m <= 512 && r_n <= 8192 && r_n >= 2*r_m;
      sel  = src_sel ? src1_stb : src0_stb;
      tick = frac_en && ok && sel && (r_acc + r_m >= r_n);
      bnd  = !frac_en || !ok || tick;
      ld   = bclk_stop && bnd && (cfg_m != r_m || cfg_n != r_n || cfg_bdiv != r_d);
      lim  = (!frac_en && r_d > 511) ? 511 : r_d;
      if (ld) begin r_bcnt = 0; r_brise = 0; end
      else if (r_mstb && !bclk_stop) begin
        if (r_bcnt >= lim) begin
          r_bcnt = 0; r_brise = 1;
          if (r_lcnt == 31) begin r_lcnt = 0; r_lr = !r_lr; end else r_lcnt++;
        end else begin r_bcnt++; r_brise = 0; end
      end else r_brise = 0;
      nm = frac_en ? tick : ext_stb;
      if (ld) r_acc = 0;
      else if (!ok) r_acc = 0;
      else if (frac_en && sel) r_acc = tick ? r_acc + r_m - r_n : r_acc + r_m;
      if (ld) begin r_m = cfg_m; r_n = cfg_n; r_d = cfg_bdiv; end
      r_mstb = nm;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks += 3;
      if (mclk_stb !== r_mstb) begin errors++; $display("FAIL R2 mclk_stb got %b exp %b t=%0t", mclk_stb, r_mstb, $time); end
      if (bclk_rise !== r_brise) begin errors++; $display("FAIL R6 bclk_rise got %b exp %b t=%0t", bclk_rise, r_brise, $time); end
      if (lrclk !== r_lr) begin errors++; $display("FAIL R8 lrclk got %b exp %b t=%0t", lrclk, r_lr, $time); end
      n_mclk += int'(mclk_stb); n_bclk += int'(bclk_rise); n_ext += int'(ext_stb);
      if (lrclk !== lr_prev) n_lr++;
      lr_prev = lrclk;
    end
  end

  task automatic cyc(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic chk(string req, int got, int lo, int hi);
    checks++;
    if (got < lo || got > hi) begin
      errors++;
      $display("FAIL %s got %0d exp %0d..%0d", req, got, lo, hi);
    end
  endtask

  task automatic prog(int m, int n, int d);
    bclk_stop = 1; cfg_m = 10'(m); cfg_n = 14'(n); cfg_bdiv = 10'(d);
    cyc(20);
    bclk_stop = 0;
    cyc(4);
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int a;
    cyc(4);
    checks += 3; // R1 reset state
    if (mclk_stb !== 0 || bclk_rise !== 0 || lrclk !== 0) begin
      errors++; $display("FAIL R1 outputs %b%b%b exp 000", mclk_stb, bclk_rise, lrclk);
    end
    rst_n = 1;
    cyc(1);
    chk("R1", int'(mclk_stb) + int'(bclk_rise) + int'(lrclk), 0, 0);
    src0_stb = 1;
    prog(1, 3, 0);
    a = n_mclk; cyc(300); chk("R2", n_mclk - a, 99, 101);
    a = n_bclk; cyc(300); chk("R6", n_bclk - a, 99, 101);
    a = n_lr;   cyc(960); chk("R8", n_lr - a, 9, 11);
    cfg_m = 1; cfg_n = 4; cfg_bdiv = 5;       // ignored while running
    a = n_mclk; cyc(300); chk("R10", n_mclk - a, 99, 101);
    prog(1, 4, 0);
    a = n_mclk; cyc(400); chk("R10", n_mclk - a, 99, 101);
    src_sel = 1; src1_stb = 0; cyc(3);
    a = n_mclk; cyc(100); chk("R3", n_mclk - a, 0, 0);
    src1_stb = 1; cyc(3);
    a = n_mclk; cyc(400); chk("R3", n_mclk - a, 99, 101);
    src_sel = 0;
    prog(1, 2, 3);
    a = n_bclk; cyc(800); chk("R6", n_bclk - a, 99, 101);
    bclk_stop = 1; cyc(2);
    a = n_bclk; cyc(100); chk("R9", n_bclk - a, 0, 0);
    bclk_stop = 0; cyc(2);
    a = n_bclk; cyc(800); chk("R9", n_bclk - a, 99, 101);
    prog(3, 5, 0);
    a = n_mclk; cyc(100); chk("R4", n_mclk - a, 0, 0);
    prog(512, 1024, 0);
    a = n_mclk; cyc(200); chk("R4", n_mclk - a, 99, 101);
    bclk_stop = 1; frac_en = 0; cyc(2);
    cfg_bdiv = 10'd1000; cyc(10); bclk_stop = 0;
    a = n_bclk; ext_stb = 1; cyc(2048); chk("R7", n_bclk - a, 3, 5);
    for (int i = 0; i < 600; i++) begin ext_stb = (i % 3 == 0); cyc(1); end
    a = n_mclk; n_ext = 0;
    for (int i = 0; i < 600; i++) begin ext_stb = (i % 5 != 1); cyc(1); end
    chk("R5", n_mclk - a, n_ext - 1, n_ext + 1);
    ext_stb = 0;
    cyc(10);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule